// File: doc/BRIEF.md
# Three-Instruction Single-Cycle Processor Core

This block is a very small processor that completes one instruction per clock. Each instruction is 8 bits wide. The core has a 4-bit program counter and four 8-bit general-purpose registers. Instructions are read from a 16-word program store. The store is built as a multiplexer whose data inputs are constants taken from a parameter vector, so the program is fixed when the block is elaborated.

A 2-to-4 one-hot decoder turns the opcode into control lines, and those lines steer the datapath. There are three instructions: register add, load of a 4-bit immediate, and a branch. The branch jumps to an absolute address when register 0 differs from a chosen register.

The register file has two combinational read ports and one write port, which is clocked and has an enable. For the branch, the first read address is forced to register 0. The core has no streaming data interface. The only pins are the clock, the reset and plain observation outputs for the program counter, the current instruction and every register, so no back-pressure rules apply.

Top module: `scpu_core`

## Requirements
- R1: While `rst_n` is low, and at the first rising edge after it is released, the program counter and all four registers read zero.
- R2: Opcode 00 in bits [7:6] is an add. The fields are destination in [5:4], first source in [3:2] and second source in [1:0]. At the clock edge the destination receives the sum of the two sources, modulo 256.
- R3: Opcode 10 is a load-immediate. The destination is in [5:4], and the 4-bit value in [3:0] is written to it zero-extended to 8 bits.
- R4: Opcode 11 is a branch. The target is in [5:2] and the compared register is in [1:0]. If register 0 differs from the compared register, the next program counter is the target.
- R5: A branch that is not taken, and every other instruction, sets the next program counter to the current value plus 1. The counter wraps from 15 to 0.
- R6: A branch, and opcode 01 (a no-operation), leave all four registers unchanged.
- R7: A register write changes only the addressed register. The other three keep their values.
- R8: `instr_o` shows, in the same cycle, program word number `pc_o`. Word n occupies bits [8n+7:8n] of the `PROG` parameter.
- R9: With the default program, the core sums 1 to 10. It settles with the program counter held at 7 and the value 55 in register 2.
- R10: A program that sums the odd numbers 1, 3, 5, 7 and 9 settles at program counter 7 with 25 in register 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_o | output | 4 | Current program counter |
| instr_o | output | 8 | Instruction word being executed this cycle |
| regs_o | output | 32 | All registers; register n in bits [8n+7:8n] |

## Verification
A faulty internal state shows at the ports on the very next rising edge. Every instruction commits its whole effect in one cycle, and `regs_o` and `pc_o` expose the complete architectural state. A wrong decode, a wrong field slice or a wrong mux select therefore makes a register or the program counter differ from an instruction-level model straight after the instruction runs. A wrong branch also sends `instr_o` down a different path in that same cycle. For this reason the bench compares the full state after every instruction and does not rely only on the final result of each program.

// File: rtl/scpu_pkg.sv
package scpu_pkg;
  localparam int XLEN      = 8;
  localparam int IW        = 8;
  localparam int PCW       = 4;
  localparam int NREG      = 4;
  localparam int RAW       = $clog2(NREG);
  localparam int ROM_DEPTH = 1 << PCW;
  localparam int IMMW      = 4;
  localparam int OPW       = 2;
  localparam int NOPS      = 1 << OPW;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 2'b00,
    OP_NOP = 2'b01,
    OP_LDI = 2'b10,
    OP_BNZ = 2'b11
  } op_e;

  typedef struct packed {
    logic sel_sum;
    logic sel_imm;
    logic wen;
    logic force_r0;
    logic is_branch;
  } ctrl_t;
endpackage

// File: rtl/scpu_rom.sv
module scpu_rom #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter logic [DEPTH*WIDTH-1:0] CONTENT = '0
) (
  input  logic [AW-1:0]    addr,
  output logic [WIDTH-1:0] data
);
  // word lines: one-hot decode of the address
  logic [DEPTH-1:0] wline;
  // per-row gated words, OR-combined into the bit lines
  logic [WIDTH-1:0] gated [DEPTH];

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_row
      assign wline[gi] = (addr == AW'(gi));
      assign gated[gi] = CONTENT[gi*WIDTH +: WIDTH] & {WIDTH{wline[gi]}};
    end
  endgenerate

  always_comb begin
    data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      data = data | gated[i];
    end
  end
endmodule

// File: rtl/scpu_regfile.sv
module scpu_regfile #(
  parameter int NREG = 4,
  parameter int XLEN = 8,
  parameter int RAW  = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [RAW-1:0]       ra1,
  output logic [XLEN-1:0]      rd1,
  input  logic [RAW-1:0]       ra2,
  output logic [XLEN-1:0]      rd2,
  input  logic                 we,
  input  logic [RAW-1:0]       wa,
  input  logic [XLEN-1:0]      wd,
  output logic [NREG*XLEN-1:0] all_o
);
  logic [XLEN-1:0] row [NREG];
  logic [NREG-1:0] row_we;
  logic [XLEN-1:0] sel1 [NREG];
  logic [XLEN-1:0] sel2 [NREG];

  genvar gr;
  generate
    for (gr = 0; gr < NREG; gr++) begin : g_reg
      // gated word line for the write port
      assign row_we[gr] = we && (wa == RAW'(gr));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          row[gr] <= '0;
        else if (row_we[gr]) row[gr] <= wd;
      end

      assign sel1[gr] = row[gr] & {XLEN{ra1 == RAW'(gr)}};
      assign sel2[gr] = row[gr] & {XLEN{ra2 == RAW'(gr)}};
      assign all_o[gr*XLEN +: XLEN] = row[gr];
    end
  endgenerate

  always_comb begin
    rd1 = '0;
    rd2 = '0;
    for (int i = 0; i < NREG; i++) begin
      rd1 = rd1 | sel1[i];
      rd2 = rd2 | sel2[i];
    end
  end
endmodule

// File: rtl/scpu_decode.sv
module scpu_decode
  import scpu_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  output ctrl_t          ctrl
);
  logic [NOPS-1:0] onehot;

  genvar go;
  generate
    for (go = 0; go < NOPS; go++) begin : g_dec
      assign onehot[go] = (opcode == OPW'(go));
    end
  endgenerate

  always_comb begin
    ctrl.sel_sum   = onehot[OP_ADD];
    ctrl.sel_imm   = onehot[OP_LDI];
    ctrl.wen       = !(onehot[OP_NOP] || onehot[OP_BNZ]);
    ctrl.force_r0  = onehot[OP_BNZ];
    ctrl.is_branch = onehot[OP_BNZ];
  end
endmodule

// File: rtl/scpu_core.sv
module scpu_core
  import scpu_pkg::*;
#(
  // word n at bits [8n+7:8n]; default sums 1..10 into register 2
  parameter logic [ROM_DEPTH*IW-1:0] PROG = {
    64'h0,
    8'hDF, 8'hD1, 8'h29, 8'h17, 8'hB1, 8'hA0, 8'h90, 8'h8A
  }
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [PCW-1:0]       pc_o,
  output logic [IW-1:0]        instr_o,
  output logic [NREG*XLEN-1:0] regs_o
);
  logic [PCW-1:0]  pc_q;
  logic [PCW-1:0]  pc_next;
  logic [IW-1:0]   instr;
  ctrl_t           ctrl;

  logic [RAW-1:0]  f_rd, f_rs1, f_rs2;
  logic [IMMW-1:0] f_imm;
  logic [PCW-1:0]  f_target;

  logic [RAW-1:0]  ra1;
  logic [XLEN-1:0] rv1, rv2;
  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] wdata;
  logic            differ;
  logic            take;

  scpu_rom #(
    .DEPTH  (ROM_DEPTH),
    .WIDTH  (IW),
    .AW     (PCW),
    .CONTENT(PROG)
  ) u_rom (
    .addr(pc_q),
    .data(instr)
  );

  scpu_decode u_dec (
    .opcode(instr[IW-1 -: OPW]),
    .ctrl  (ctrl)
  );

  // field extraction
  assign f_rd     = instr[5:4];
  assign f_rs1    = instr[3:2];
  assign f_rs2    = instr[1:0];
  assign f_imm    = instr[IMMW-1:0];
  assign f_target = instr[5:2];

  // read port 1 is pinned to register 0 for the branch
  assign ra1 = ctrl.force_r0 ? '0 : f_rs1;

  scpu_regfile #(
    .NREG(NREG),
    .XLEN(XLEN),
    .RAW (RAW)
  ) u_rf (
    .clk  (clk),
    .rst_n(rst_n),
    .ra1  (ra1),
    .rd1  (rv1),
    .ra2  (f_rs2),
    .rd2  (rv2),
    .we   (ctrl.wen),
    .wa   (f_rd),
    .wd   (wdata),
    .all_o(regs_o)
  );

  assign sum     = rv1 + rv2;
  assign imm_ext = {{(XLEN-IMMW){1'b0}}, f_imm};
  assign wdata   = (sum & {XLEN{ctrl.sel_sum}}) | (imm_ext & {XLEN{ctrl.sel_imm}});

  assign differ  = (rv1 != rv2);
  assign take    = ctrl.is_branch && differ;
  assign pc_next = take ? f_target : pc_q + PCW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_next;
  end

  assign pc_o    = pc_q;
  assign instr_o = instr;
endmodule

// File: rtl/scpu_core_sva.sv
module scpu_core_sva (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  pc_o,
  input logic [7:0]  instr_o,
  input logic [31:0] regs_o
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  function automatic logic [7:0] rget(input logic [31:0] v, input logic [1:0] i);
    return v[i*8 +: 8];
  endfunction

  // R2: add result lands in the destination
  p_add_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(instr_o[7:6]) == 2'b00) |->
      rget(regs_o, $past(instr_o[5:4])) ==
      8'(rget($past(regs_o), $past(instr_o[3:2])) + rget($past(regs_o), $past(instr_o[1:0]))));

  // R3: zero-extended immediate lands in the destination
  p_ldi_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(instr_o[7:6]) == 2'b10) |->
      rget(regs_o, $past(instr_o[5:4])) == {4'h0, $past(instr_o[3:0])});

  // R4: taken branch goes to the target
  p_branch_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(instr_o[7:6]) == 2'b11 &&
     rget($past(regs_o), 2'd0) != rget($past(regs_o), $past(instr_o[1:0]))) |->
      pc_o == $past(instr_o[5:2]));

  // R5: sequential advance with wrap
  p_pc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !($past(instr_o[7:6]) == 2'b11 &&
     rget($past(regs_o), 2'd0) != rget($past(regs_o), $past(instr_o[1:0])))) |->
      pc_o == 4'($past(pc_o) + 4'd1));

  // R6: branch and no-op leave registers alone
  p_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(instr_o[6])) |-> $stable(regs_o));
endmodule

bind scpu_core scpu_core_sva u_sva (
  .clk    (clk),
  .rst_n  (rst_n),
  .pc_o   (pc_o),
  .instr_o(instr_o),
  .regs_o (regs_o)
);

// File: tb/scpu_core_tb.sv
module scpu_core_tb;
  localparam int NP = 3;

  // program 0: sum 1..10; program 1: odd sum; program 2: corner cases
  localparam logic [127:0] PROGS [NP] = '{
    {64'h0, 8'hDF, 8'hD1, 8'h29, 8'h17, 8'hB1, 8'hA0, 8'h90, 8'h8A},
    {64'h0, 8'hDF, 8'hD1, 8'h17, 8'h29, 8'hB2, 8'hA0, 8'h91, 8'h8B},
    {8'h5A, 8'h40, 8'hA2, 8'hA1, 8'hFB, 8'hB9, 8'hC8, 8'h7F,
     8'h14, 8'h14, 8'h15, 8'h15, 8'h15, 8'h15, 8'h9F, 8'h8F}
  };
  localparam int RUN_CYC [NP] = '{40, 25, 14};
  localparam int EXP_PC  [NP] = '{7, 7, 0};
  localparam int EXP_IDX [NP] = '{2, 2, 1};
  localparam int EXP_VAL [NP] = '{55, 25, 14};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]  pc_w   [NP];
  logic [7:0]  ins_w  [NP];
  logic [31:0] regs_w [NP];

  genvar g;
  generate
    for (g = 0; g < NP; g++) begin : g_dut
      scpu_core #(.PROG(PROGS[g])) u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .pc_o   (pc_w[g]),
        .instr_o(ins_w[g]),
        .regs_o (regs_w[g])
      );
    end
  endgenerate

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [3:0] m_pc;
  logic [7:0] m_reg [4];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected end before 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mflat();
    return {m_reg[3], m_reg[2], m_reg[1], m_reg[0]};
  endfunction

  task automatic mreset();
    m_pc = '0;
    for (int i = 0; i < 4; i++) m_reg[i] = '0;
  endtask

  // instruction-level model; returns the tag of the executed class
  task automatic mstep(input int p, output string rtag, output string ptag);
    logic [7:0] w;
    w = PROGS[p][m_pc*8 +: 8];
    ptag = "R5";
    case (w[7:6])
      2'b00: begin
        m_reg[w[5:4]] = m_reg[w[3:2]] + m_reg[w[1:0]];
        rtag = "R2/R7";
        m_pc = m_pc + 4'd1;
      end
      2'b10: begin
        m_reg[w[5:4]] = {4'h0, w[3:0]};
        rtag = "R3/R7";
        m_pc = m_pc + 4'd1;
      end
      2'b11: begin
        rtag = "R6";
        if (m_reg[0] != m_reg[w[1:0]]) begin
          m_pc = w[5:2];
          ptag = "R4";
        end else begin
          m_pc = m_pc + 4'd1;
        end
      end
      default: begin
        rtag = "R6";
        m_pc = m_pc + 4'd1;
      end
    endcase
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      check("R1 pc in reset", 32'(pc_w[p]), 32'd0);
      check("R1 regs in reset", regs_w[p], 32'd0);
    end
    rst_n = 1'b1;
  endtask

  initial begin
    string rt, pt;
    for (int p = 0; p < NP; p++) begin
      do_reset();
      mreset();
      for (int c = 0; c < RUN_CYC[p]; c++) begin
        check("R8 instr fetch", 32'(ins_w[p]), 32'(PROGS[p][m_pc*8 +: 8]));
        mstep(p, rt, pt);
        @(negedge clk);
        check(pt, 32'(pc_w[p]), 32'(m_pc));
        check(rt, regs_w[p], mflat());
      end
      check(p == 1 ? "R10 final pc" : (p == 0 ? "R9 final pc" : "R5 wrap pc"),
            32'(pc_w[p]), 32'(EXP_PC[p]));
      check(p == 1 ? "R10 result" : (p == 0 ? "R9 result" : "R2 wrap sum"),
            32'(regs_w[p][EXP_IDX[p]*8 +: 8]), 32'(EXP_VAL[p]));
    end

    // directed: reset in mid-run clears state (R1)
    do_reset();
    repeat (6) @(negedge clk);
    check("R1 running before reset", 32'(pc_w[0]), 32'd6);
    rst_n = 1'b0;
    #1;
    check("R1 async pc clear", 32'(pc_w[0]), 32'd0);
    check("R1 async regs clear", regs_w[0], 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first step after reset", 32'(pc_w[0]), 32'd1);
    check("R3 first load after reset", regs_w[0], 32'h0000_000A);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule